// File: doc/BRIEF.md
# SQE test pulse generator

This block produces the signal-quality-error test burst that a multi-port transceiver multiplexer returns to a DTE once that DTE has finished sending a frame. It watches the transmit activity of every DTE port and notes which port carried the frame that just ended. After a fixed delay in the inter-packet gap, it raises a burst enable on that port's collision output and on no other port. For the length of a blanking window it also asserts a block flag on every other port, so those ports cannot see the test burst. In the same window it raises a gap flag, which tells the collision arbiter to disregard collision activity on the medium attachment side.

The burst enables and block flags control a shared 10 MHz collision oscillator, which is outside this block. All delays are parameters counted in clock cycles. With the defaults at a 20 MHz clock, the burst starts 1.1 µs after the transmit input goes idle, lasts 1.0 µs, and the blanking window is 5.5 µs long. A 2-bit mode input selects whether the test burst is produced at all. A per-port jabber input suppresses the burst on any port that is being held off the network.

Top module: `sqe_test_gen`

## Requirements
- R1: While rst_n is low, and after reset until a transmission ends, sqe_en, blank_col and gap_win are all zero.
- R2: A transmission ends at a clock edge where tx_act is all zero and tx_act at the previous edge was not all zero. gap_win is high from the cycle after that edge for exactly BLANK_CYC cycles, unless R7 cancels it first.
- R3: The originating port's bit of sqe_en goes high DELAY_CYC cycles after gap_win rises and stays high for BURST_CYC cycles. The sqe_en bits of all other ports stay low.
- R4: blank_col is high on every port except the originating port for exactly the cycles in which gap_win is high. blank_col is never high on the originating port.
- R5: mode encodes 2'b11 = loopback with SQE test, 2'b01 = loopback without SQE test, 2'b00 = neither, and 2'b10 = reserved, treated as neither. sqe_en is zero unless mode is 2'b11. The window and the blocking of R2 and R4 run in every mode.
- R6: While jab[p] is high, sqe_en[p] is zero. A jabber flag on a port that did not originate the frame has no effect on the burst.
- R7: If any tx_act bit is high at a clock edge while gap_win is high, and fewer than DELAY_CYC window cycles have passed, gap_win and blank_col are low from the next cycle on and no burst is issued for that frame.
- R8: The originating port is the lowest-indexed port whose tx_act was high at the edge before the end. When ports 0 and 1 stop at the same time, port 0 receives the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 20 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_act | input | NPORTS | Per-port transmit activity (unsquelched) |
| jab | input | NPORTS | Per-port jabber state |
| mode | input | 2 | Loopback / SQE configuration mode |
| sqe_en | output | NPORTS | Per-port SQE burst enable for the collision oscillator |
| blank_col | output | NPORTS | Per-port collision output block |
| gap_win | output | 1 | Gap window; medium-side collision input to be ignored |

## Verification
gap_win and blank_col change one cycle after the clock edge that first samples the idle transmit input. sqe_en follows DELAY_CYC cycles later and lasts BURST_CYC cycles. sqe_en also reacts in the same cycle to mode and jab, because it gates them combinationally. The bench drives its inputs just after each rising edge and pushes, for every cycle it drives, one expected item derived from the requirements. The monitor pops each item at the following falling edge, so every comparison falls in the cycle where the registered state has settled and any combinational gating from the inputs just driven has taken effect.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  typedef enum logic [1:0] {
    MODE_NONE     = 2'b00,
    MODE_LOOP     = 2'b01,
    MODE_RSVD     = 2'b10,
    MODE_LOOP_SQE = 2'b11
  } sqe_mode_e;
endpackage

// File: rtl/sqe_end_detect.sv
// Finds the end of a transmission and the port that carried it.
module sqe_end_detect #(
  parameter int NPORTS = 2,
  parameter int IDXW   = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] tx_act,
  output logic              end_pulse,
  output logic [IDXW-1:0]   end_port,
  output logic              any_act
);
  logic [NPORTS-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_act;
  end

  assign any_act   = |tx_act;
  assign end_pulse = (|tx_q) & ~any_act;

  // lowest index wins
  always_comb begin
    end_port = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (tx_q[i]) end_port = IDXW'(i);
    end
  end
endmodule

// File: rtl/sqe_gap_timer.sv
// Counts the gap window and marks the burst phase inside it.
module sqe_gap_timer #(
  parameter int DELAY_CYC = 22,
  parameter int BURST_CYC = 20,
  parameter int BLANK_CYC = 110,
  parameter int TW        = $clog2(BLANK_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic any_act,
  output logic win,
  output logic burst
);
  localparam logic [TW-1:0] T_DLY  = TW'(DELAY_CYC);
  localparam logic [TW-1:0] T_BEND = TW'(DELAY_CYC + BURST_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(BLANK_CYC - 1);

  logic [TW-1:0] t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= 1'b0;
      t   <= '0;
    end else if (start) begin
      win <= 1'b1;
      t   <= '0;
    end else if (win) begin
      if (any_act && (t < T_DLY)) win <= 1'b0;
      else if (t == T_LAST)       win <= 1'b0;
      t <= t + 1'b1;
    end
  end

  assign burst = win && (t >= T_DLY) && (t < T_BEND);
endmodule

// File: rtl/sqe_port_gate.sv
// Holds the originating port and fans out per-port enables and blocks.
module sqe_port_gate #(
  parameter int NPORTS = 2,
  parameter int IDXW   = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDXW-1:0]   start_port,
  input  logic              win,
  input  logic              burst,
  input  logic              sqe_on,
  input  logic [NPORTS-1:0] jab,
  output logic [NPORTS-1:0] sqe_en,
  output logic [NPORTS-1:0] blank_col
);
  logic [IDXW-1:0] orig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     orig <= '0;
    else if (start) orig <= start_port;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic is_orig;
    assign is_orig      = (orig == IDXW'(p));
    assign sqe_en[p]    = burst && sqe_on && is_orig && !jab[p];
    assign blank_col[p] = win && !is_orig;
  end
endmodule

// File: rtl/sqe_test_gen.sv
module sqe_test_gen #(
  parameter int NPORTS    = 2,
  parameter int DELAY_CYC = 22,
  parameter int BURST_CYC = 20,
  parameter int BLANK_CYC = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] tx_act,
  input  logic [NPORTS-1:0] jab,
  input  logic [1:0]        mode,
  output logic [NPORTS-1:0] sqe_en,
  output logic [NPORTS-1:0] blank_col,
  output logic              gap_win
);
  import sqe_pkg::*;

  localparam int IDXW = $clog2(NPORTS);

  logic            end_pulse;
  logic [IDXW-1:0] end_port;
  logic            any_act;
  logic            burst;
  logic            sqe_on;

  assign sqe_on = (sqe_mode_e'(mode) == MODE_LOOP_SQE);

  sqe_end_detect #(.NPORTS(NPORTS), .IDXW(IDXW)) u_end (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act),
    .end_pulse(end_pulse), .end_port(end_port), .any_act(any_act)
  );

  sqe_gap_timer #(.DELAY_CYC(DELAY_CYC), .BURST_CYC(BURST_CYC),
                  .BLANK_CYC(BLANK_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(end_pulse), .any_act(any_act),
    .win(gap_win), .burst(burst)
  );

  sqe_port_gate #(.NPORTS(NPORTS), .IDXW(IDXW)) u_gate (
    .clk(clk), .rst_n(rst_n), .start(end_pulse), .start_port(end_port),
    .win(gap_win), .burst(burst), .sqe_on(sqe_on), .jab(jab),
    .sqe_en(sqe_en), .blank_col(blank_col)
  );
endmodule

// File: rtl/sqe_test_gen_chk.sv
module sqe_test_gen_chk #(
  parameter int NPORTS    = 2,
  parameter int DELAY_CYC = 22,
  parameter int BURST_CYC = 20,
  parameter int BLANK_CYC = 110
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] tx_act,
  input logic [NPORTS-1:0] jab,
  input logic [1:0]        mode,
  input logic [NPORTS-1:0] sqe_en,
  input logic [NPORTS-1:0] blank_col,
  input logic              gap_win
);
  localparam int CW = $clog2(BLANK_CYC + 2);
  localparam logic [CW-1:0] C_DLY = CW'(DELAY_CYC);

  logic [NPORTS-1:0] prev_tx;
  logic [CW-1:0]     cw;
  logic              ended;

  assign ended = (|prev_tx) && !(|tx_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tx <= '0;
      cw      <= '0;
    end else begin
      prev_tx <= tx_act;
      if (ended)        cw <= '0;
      else if (gap_win) cw <= cw + 1'b1;
      else              cw <= '0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (sqe_en == '0 && blank_col == '0 && !gap_win)
        else $error("R1 outputs active in reset");
    end
  end

  a_r2_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ended |=> gap_win);
  a_r3_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sqe_en));
  a_r3_burst_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (|sqe_en) |-> gap_win);
  a_r3_burst_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_win && cw == C_DLY && mode == 2'b11 && jab == '0) |-> (|sqe_en));
  a_r4_orig_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sqe_en & blank_col) == '0);
  a_r4_block_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (|blank_col) |-> gap_win);
  a_r5_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |-> (sqe_en == '0));
  a_r6_jabber_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sqe_en & jab) == '0);
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_win && (|tx_act) && cw < C_DLY) |=> !gap_win);
endmodule

bind sqe_test_gen sqe_test_gen_chk #(
  .NPORTS(NPORTS), .DELAY_CYC(DELAY_CYC),
  .BURST_CYC(BURST_CYC), .BLANK_CYC(BLANK_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .jab(jab), .mode(mode),
  .sqe_en(sqe_en), .blank_col(blank_col), .gap_win(gap_win)
);

// File: tb/sqe_test_gen_tb_top.sv
module sqe_test_gen_tb_top;
  localparam int NP    = 2;
  localparam int D     = 22;
  localparam int B     = 20;
  localparam int BLANK = 110;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] tx_act = '0;
  logic [NP-1:0] jab = '0;
  logic [1:0]    mode = 2'b11;
  logic [NP-1:0] sqe_en, blank_col;
  logic          gap_win;

  always #2 clk = ~clk;

  sqe_test_gen #(.NPORTS(NP), .DELAY_CYC(D), .BURST_CYC(B), .BLANK_CYC(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .jab(jab), .mode(mode),
    .sqe_en(sqe_en), .blank_col(blank_col), .gap_win(gap_win)
  );

  typedef struct {
    logic [NP-1:0] sqe;
    logic [NP-1:0] blk;
    logic          gap;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // requirement-level expectation state
  bit            m_win = 0;
  int            m_t = 0;
  int            m_orig = 0;
  logic [NP-1:0] h_p = '0, h_pp = '0;

  task automatic chk(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic step(input logic [NP-1:0] tx, input logic [NP-1:0] jb,
                      input logic [1:0] md, input string tag);
    exp_t e;
    @(posedge clk); #1;
    tx_act = tx; jab = jb; mode = md;
    // R2/R8: end seen at the edge just passed
    if ((|h_pp) && !(|h_p)) begin
      m_win = 1; m_t = 0;
      m_orig = h_pp[0] ? 0 : 1;
    end else if (m_win) begin
      if ((|h_p) && m_t < D) m_win = 0;       // R7
      else if (m_t == BLANK - 1) m_win = 0;   // R2 length
      m_t++;
    end
    h_pp = h_p; h_p = tx;
    for (int p = 0; p < NP; p++) begin
      e.sqe[p] = m_win && m_t >= D && m_t < D + B && md == 2'b11
                 && m_orig == p && !jb[p];
      e.blk[p] = m_win && m_orig != p;
    end
    e.gap = m_win;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic frame(input logic [NP-1:0] tx, input int len, input logic [NP-1:0] jb,
                       input logic [1:0] md, input string tag);
    for (int i = 0; i < len; i++) step(tx, jb, md, tag);
    for (int i = 0; i < BLANK + 10; i++) step('0, jb, md, tag);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(sqe_en == e.sqe && blank_col == e.blk && gap_win == e.gap, e.tag,
            $sformatf("sqe=%b blk=%b gap=%b expected sqe=%b blk=%b gap=%b",
                      sqe_en, blank_col, gap_win, e.sqe, e.blk, e.gap));
      end
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(sqe_en == '0 && blank_col == '0 && gap_win == 1'b0, "R1",
          $sformatf("in reset sqe=%b blk=%b gap=%b expected all 0",
                    sqe_en, blank_col, gap_win));
    end
    @(posedge clk); #1; rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step('0, '0, 2'b11, "R1");
    frame(2'b01, 4, 2'b00, 2'b11, "R2 R3 R4");
    frame(2'b10, 6, 2'b00, 2'b11, "R3 R4");
    frame(2'b01, 3, 2'b00, 2'b01, "R5 loop only");
    frame(2'b10, 3, 2'b00, 2'b00, "R5 none");
    frame(2'b01, 3, 2'b00, 2'b10, "R5 reserved");
    frame(2'b01, 3, 2'b01, 2'b11, "R6 own jabber");
    frame(2'b01, 3, 2'b10, 2'b11, "R6 other jabber");
    frame(2'b11, 4, 2'b00, 2'b11, "R8 joint end");
    for (int i = 0; i < 3; i++) step(2'b11, '0, 2'b11, "R8 staggered");
    frame(2'b10, 3, 2'b00, 2'b11, "R8 staggered");
    for (int i = 0; i < 3; i++) step(2'b01, '0, 2'b11, "R7");
    for (int i = 0; i < 6; i++) step('0, '0, 2'b11, "R7");
    frame(2'b10, 2, 2'b00, 2'b11, "R7 cancel");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule